// File: doc/BRIEF.md
# Fixed-Wait Static Memory Controller

This block connects an on-chip request port to asynchronous external memory split into three regions: boot ROM, static RAM and a peripheral (IO) window. A request carries an address, a write flag, a size (byte, halfword or word) and write data. The controller turns it into chip-select, output-enable, write-enable and byte-lane strobes with a fixed number of wait states per region. The wait-state counts are set at elaboration and cannot be changed at run time. The external data bus is bidirectional. It is modelled here as an input bus, an output bus and an output-enable.

The RAM path is always 32 bits wide. The ROM is fixed at elaboration to 8 or 32 bits. In 8-bit mode, every ROM read is built from four consecutive byte fetches, so the requester still receives a full 32-bit word. Some RAM parts have no byte-enable pins. For these, an elaboration switch turns sub-word RAM writes into a read, a merge and a full-word write. The address selects the RAM bank and the ROM bank, using a bank size and a ROM bank bit that are both parameters.

Top module: `static_mem_ctrl`

## Requirements
- R1: Region decode uses req_addr[31:29]. 000 selects ROM, 001 selects IO, and every other value selects RAM. ROM bank 1 (rom_cs_n[1]) is used when req_addr[ROM_BANK_BIT] is 1, otherwise bank 0. At most one chip select is low in any cycle.
- R2: The RAM bank index is req_addr[log2(BANK_KB*1024) +: log2(SRAM_BANKS)], which is bit 10 by default. Bank i drives ram_cs_n[i] low.
- R3: Every memory access has a setup cycle first. In that cycle the chip select is low and both strobes are high. Then the strobe stays low for the region's wait-state count plus one cycles: mem_oe_n for reads, mem_we_n for writes. req_ready is high for exactly one cycle, which is the last strobe cycle.
- R4: In the cycle after req_ready, all chip selects and strobes are high. A new request may be accepted in that cycle, so back-to-back accesses are separated by exactly one cycle with no chip select.
- R5: A RAM or IO read returns mem_din on req_rdata in the req_ready cycle.
- R6: With an 8-bit ROM, a read performs four byte fetches with mem_addr[1:0] = 0, 1, 2, 3. Each fetch lasts PROM_WS+1 cycles, and mem_oe_n stays low throughout. The byte from fetch k (taken from mem_din[7:0]) lands in req_rdata bits [31-8k:24-8k].
- R7: Write data is passed to mem_dout unchanged. Lane i covers data bits [8i+7:8i] and is enabled by mem_bsel_n[i] low. A byte at offset k uses lane 3-k. A halfword at offset 0 uses lanes 3 and 2, and at offset 2 uses lanes 1 and 0. A word uses all lanes, and so does every read.
- R8: With read-modify-write enabled, a byte or halfword RAM write runs as follows: a read strobe of RAM_WS+1 cycles, one setup cycle, then a write strobe of RAM_WS+1 cycles. The write uses all lanes and carries the old word with the new lanes merged in. req_ready is raised only once, at the end.
- R9: mem_doe is high only in write-strobe cycles and in the single cycle after the last one. mem_dout stays unchanged through that extra cycle.
- R10: A write to the ROM region drives no chip select and no strobe. req_ready goes high in the cycle after acceptance.
- R11: During reset, all chip selects and strobes are high, and mem_doe and req_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data in lane position |
| req_ready | output | 1 | Access complete (one cycle) |
| req_rdata | output | 32 | Read data, valid with req_ready |
| mem_addr | output | ADDR_W | External address |
| mem_din | input | 32 | Data bus, inbound |
| mem_dout | output | 32 | Data bus, outbound |
| mem_doe | output | 1 | Data bus driver enable |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bsel_n | output | 4 | Byte lane selects, active low |
| rom_cs_n | output | 2 | ROM bank chip selects |
| ram_cs_n | output | SRAM_BANKS | RAM bank chip selects |
| io_cs_n | output | 1 | IO chip select |

## Verification
The assertions assume the requester holds a request steady until req_ready. They also assume the requester either drops req_valid or presents the next request in the cycle after req_ready, and never raises it while an access is still in flight. The bench keeps to these rules: it changes inputs only on falling edges, and it releases or replaces the request in the same falling edge where it sees req_ready. The bench's memory model reads only while a chip select and mem_oe_n are low, and writes only the lanes selected under mem_we_n. Because of this, a wrong decode, a wrong lane or a skipped merge shows up as wrong data when the location is read back.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        RGN_PROM = 2'd0,
        RGN_SRAM = 2'd1,
        RGN_IO   = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_SKIP   = 3'd3,
        ST_TAIL   = 3'd4
    } state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Lane i covers data bits [8i+7:8i]; byte offset k maps to lane 3-k.
    function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
        case (size)
            SZ_BYTE: lane_mask = 4'b1000 >> off;
            SZ_HALF: lane_mask = off[1] ? 4'b0011 : 4'b1100;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/smc_region_decode.sv
module smc_region_decode
    import smc_pkg::*;
#(
    parameter int ROM_BANK_BIT = 20,
    parameter int SRAM_BANKS   = 2,
    parameter int BANK_KB      = 1
) (
    input  logic [31:0]           addr,
    output region_e               region,
    output logic [1:0]            rom_sel,
    output logic [SRAM_BANKS-1:0] ram_sel
);
    localparam int BANK_LSB = $clog2(BANK_KB * 1024);
    localparam int BANK_W   = (SRAM_BANKS > 1) ? $clog2(SRAM_BANKS) : 1;

    logic unused_addr;
    assign unused_addr = ^addr;

    always_comb begin
        case (addr[31:29])
            3'b000:  region = RGN_PROM;
            3'b001:  region = RGN_IO;
            default: region = RGN_SRAM;
        endcase
    end

    assign rom_sel = addr[ROM_BANK_BIT] ? 2'b10 : 2'b01;

    generate
        if (SRAM_BANKS == 1) begin : g_one_bank
            assign ram_sel = 1'b1;
        end else begin : g_banks
            logic [BANK_W-1:0] bank_idx;
            assign bank_idx = addr[BANK_LSB +: BANK_W];
            for (genvar i = 0; i < SRAM_BANKS; i++) begin : g_sel
                assign ram_sel[i] = (bank_idx == BANK_W'(i));
            end
        end
    endgenerate

endmodule

// File: rtl/smc_lane_merge.sv
module smc_lane_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] old_word,
    input  logic [LANES*8-1:0] new_word,
    input  logic [LANES-1:0]   lane_en,
    output logic [LANES*8-1:0] merged
);
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign merged[i*8 +: 8] = lane_en[i] ? new_word[i*8 +: 8] : old_word[i*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl
    import smc_pkg::*;
#(
    parameter int PROM_WS      = 2,
    parameter int RAM_WS       = 1,
    parameter int IO_WS        = 3,
    parameter bit PROM_BYTE    = 1'b1,
    parameter bit USE_RMW      = 1'b1,
    parameter int SRAM_BANKS   = 2,
    parameter int BANK_KB      = 1,
    parameter int ROM_BANK_BIT = 20,
    parameter int ADDR_W       = 28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [31:0]           req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  req_ready,
    output logic [31:0]           req_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [31:0]           mem_din,
    output logic [31:0]           mem_dout,
    output logic                  mem_doe,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [3:0]            mem_bsel_n,
    output logic [1:0]            rom_cs_n,
    output logic [SRAM_BANKS-1:0] ram_cs_n,
    output logic                  io_cs_n
);
    localparam int MAX_AB = (PROM_WS > RAM_WS) ? PROM_WS : RAM_WS;
    localparam int MAXWS  = (MAX_AB > IO_WS) ? MAX_AB : IO_WS;
    localparam int CW     = (MAXWS > 0) ? $clog2(MAXWS + 1) : 1;

    typedef struct packed {
        state_e                st;
        region_e               rgn;
        logic                  wr;
        logic                  rmw;
        logic                  rmw_wr;
        logic [1:0]            bidx;
        logic [CW-1:0]         cnt;
        logic [3:0]            mask;
        logic [1:0]            rom_sel;
        logic [SRAM_BANKS-1:0] ram_sel;
        logic [31:0]           addr;
        logic [31:0]           wdata;
        logic [23:0]           rbuf;
    } ctl_t;

    ctl_t s_q, s_d;

    function automatic logic [CW-1:0] ws_of(input region_e r);
        case (r)
            RGN_PROM: ws_of = CW'(PROM_WS);
            RGN_SRAM: ws_of = CW'(RAM_WS);
            default:  ws_of = CW'(IO_WS);
        endcase
    endfunction

    region_e               dec_rgn;
    logic [1:0]            dec_rom;
    logic [SRAM_BANKS-1:0] dec_ram;
    logic [31:0]           merged;

    smc_region_decode #(
        .ROM_BANK_BIT(ROM_BANK_BIT),
        .SRAM_BANKS  (SRAM_BANKS),
        .BANK_KB     (BANK_KB)
    ) u_decode (
        .addr   (req_addr),
        .region (dec_rgn),
        .rom_sel(dec_rom),
        .ram_sel(dec_ram)
    );

    smc_lane_merge #(.LANES(4)) u_merge (
        .old_word(mem_din),
        .new_word(s_q.wdata),
        .lane_en (s_q.mask),
        .merged  (merged)
    );

    logic byte_rom, last_unit, more_bytes, need_wphase;
    assign byte_rom    = PROM_BYTE && (s_q.rgn == RGN_PROM);
    assign last_unit   = (s_q.cnt == '0);
    assign more_bytes  = byte_rom && (s_q.bidx != 2'd3);
    assign need_wphase = s_q.rmw && !s_q.rmw_wr;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE, ST_TAIL: begin
                s_d.st = ST_IDLE;
                if (req_valid) begin
                    s_d.rgn     = dec_rgn;
                    s_d.wr      = req_write;
                    s_d.addr    = req_addr;
                    s_d.wdata   = req_wdata;
                    s_d.mask    = lane_mask(req_size, req_addr[1:0]);
                    s_d.rom_sel = dec_rom;
                    s_d.ram_sel = dec_ram;
                    s_d.cnt     = ws_of(dec_rgn);
                    s_d.bidx    = 2'd0;
                    s_d.rmw_wr  = 1'b0;
                    s_d.rmw     = USE_RMW && req_write && (dec_rgn == RGN_SRAM)
                                  && (s_d.mask != 4'hF);
                    s_d.st      = (req_write && dec_rgn == RGN_PROM) ? ST_SKIP : ST_SETUP;
                end
            end
            ST_SETUP: s_d.st = ST_STROBE;
            ST_STROBE: begin
                if (!last_unit) begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end else if (more_bytes) begin
                    s_d.rbuf = {s_q.rbuf[15:0], mem_din[7:0]};
                    s_d.bidx = s_q.bidx + 2'd1;
                    s_d.cnt  = ws_of(s_q.rgn);
                end else if (need_wphase) begin
                    s_d.wdata  = merged;
                    s_d.rmw_wr = 1'b1;
                    s_d.cnt    = ws_of(s_q.rgn);
                    s_d.st     = ST_SETUP;
                end else begin
                    s_d.st = ST_TAIL;
                end
            end
            ST_SKIP: s_d.st = ST_TAIL;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic in_access, strobe, wr_phase;
    logic [1:0] addr_lo;
    assign in_access = (s_q.st == ST_SETUP) || (s_q.st == ST_STROBE);
    assign strobe    = (s_q.st == ST_STROBE);
    assign wr_phase  = s_q.wr && (!s_q.rmw || s_q.rmw_wr);
    assign addr_lo   = byte_rom ? s_q.bidx : s_q.addr[1:0];

    assign mem_oe_n   = !(strobe && !wr_phase);
    assign mem_we_n   = !(strobe && wr_phase);
    assign mem_doe    = (strobe && wr_phase)
                      || ((s_q.st == ST_TAIL) && s_q.wr && (s_q.rgn != RGN_PROM));
    assign mem_dout   = s_q.wdata;
    assign mem_bsel_n = in_access ? ~((s_q.wr && !s_q.rmw) ? s_q.mask : 4'hF) : 4'hF;
    assign mem_addr   = {s_q.addr[ADDR_W-1:2], addr_lo};
    assign rom_cs_n   = ~(s_q.rom_sel & {2{in_access && (s_q.rgn == RGN_PROM)}});
    assign ram_cs_n   = ~(s_q.ram_sel & {SRAM_BANKS{in_access && (s_q.rgn == RGN_SRAM)}});
    assign io_cs_n    = !(in_access && (s_q.rgn == RGN_IO));
    assign req_ready  = (strobe && last_unit && !more_bytes && !need_wphase)
                      || (s_q.st == ST_SKIP);

    generate
        if (PROM_BYTE) begin : g_rom8
            assign req_rdata = byte_rom ? {s_q.rbuf, mem_din[7:0]} : mem_din;
        end else begin : g_rom32
            assign req_rdata = mem_din;
        end
    endgenerate

    logic unused_state;
    assign unused_state = ^{s_q.addr, s_q.rbuf};

    logic [SRAM_BANKS+2:0] cs_act;
    assign cs_act = {~rom_cs_n, ~ram_cs_n, ~io_cs_n};

    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act));

    assert_strobe_under_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (cs_act != '0));

    assert_cs_leads_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_oe_n) || $fell(mem_we_n)) |-> ($past(cs_act) == cs_act));

    assert_ready_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_gap_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> (cs_act == '0 && mem_oe_n && mem_we_n));

    assert_no_dual_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_doe_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> (!mem_we_n || $past(!mem_we_n)));

    assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_doe && mem_we_n) |-> $stable(mem_dout));

    assert_rom_never_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (rom_cs_n == 2'b11));

endmodule

// File: tb/static_mem_ctrl_bench.sv
`timescale 1ns/1ps
module static_mem_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready;
    logic [31:0] req_rdata;
    logic [27:0] mem_addr;
    logic [31:0] mem_din, mem_dout;
    logic        mem_doe, mem_oe_n, mem_we_n, io_cs_n;
    logic [3:0]  mem_bsel_n;
    logic [1:0]  rom_cs_n, ram_cs_n;

    always #2 clk = ~clk;

    static_mem_ctrl u_static_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .mem_addr(mem_addr),
        .mem_din(mem_din), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bsel_n(mem_bsel_n),
        .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n)
    );

    // external memory model
    logic [31:0] sram [0:31];
    logic [31:0] iom  [0:3];

    function automatic logic [7:0] rom_byte(input logic [27:0] a, input logic hi_bank);
        return a[7:0] ^ (hi_bank ? 8'h3C : 8'hA5);
    endfunction

    always_comb begin
        mem_din = '0;
        if (!mem_oe_n) begin
            if (rom_cs_n != 2'b11)      mem_din = {24'h0, rom_byte(mem_addr, !rom_cs_n[1])};
            else if (ram_cs_n != 2'b11) mem_din = sram[{!ram_cs_n[1], mem_addr[5:2]}];
            else if (!io_cs_n)          mem_din = iom[mem_addr[3:2]];
        end
    end

    always @(negedge clk) begin
        if (!mem_we_n) begin
            for (int i = 0; i < 4; i++) begin
                if (!mem_bsel_n[i]) begin
                    if (ram_cs_n != 2'b11)
                        sram[{!ram_cs_n[1], mem_addr[5:2]}][i*8 +: 8] <= mem_dout[i*8 +: 8];
                    else if (!io_cs_n)
                        iom[mem_addr[3:2]][i*8 +: 8] <= mem_dout[i*8 +: 8];
                end
            end
        end
    end

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] cs_vec();
        return {~rom_cs_n, ~ram_cs_n, ~io_cs_n};
    endfunction

    int          r_lat, r_oe, r_we, r_rdy, r_doe_bad;
    logic [4:0]  r_cs;
    logic [31:0] r_rdata, r_dout_we, r_dout_tail;
    logic [3:0]  r_bsel;
    logic        r_setup_ok, r_tail_ok, r_tail_doe;

    // Called right after a falling edge. Presents one request and traces it through its gap cycle.
    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd);
        int c = 0;
        bit done = 1'b0;
        logic prev_we = 1'b0;
        r_lat = 0; r_oe = 0; r_we = 0; r_rdy = 0; r_doe_bad = 0; r_cs = '0;
        r_rdata = '0; r_dout_we = '0; r_bsel = 4'hF; r_setup_ok = 1'b0;
        req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        while (!done) begin
            @(negedge clk);
            c++;
            if (c == 1) r_setup_ok = (cs_vec() != '0) && mem_oe_n && mem_we_n;
            if (!mem_oe_n) r_oe++;
            if (!mem_we_n) begin r_we++; r_bsel = mem_bsel_n; r_dout_we = mem_dout; end
            if (mem_doe && !(!mem_we_n || prev_we)) r_doe_bad++;
            prev_we = !mem_we_n;
            r_cs |= cs_vec();
            if (req_ready) begin
                r_rdy++; r_rdata = req_rdata; r_lat = c; done = 1'b1; req_valid = 1'b0;
            end
            if (c > 100) begin
                chk("R3", "access never completed", 32'(c), 32'd0);
                req_valid = 1'b0; done = 1'b1;
            end
        end
        @(negedge clk);
        if (req_ready) r_rdy++;
        if (mem_doe && !(!mem_we_n || prev_we)) r_doe_bad++;
        r_tail_ok   = (cs_vec() == '0) && mem_oe_n && mem_we_n;
        r_tail_doe  = mem_doe;
        r_dout_tail = mem_dout;
    endtask

    task automatic t_reset();
        chk("R11", "rom_cs_n", 32'(rom_cs_n), 32'h3);
        chk("R11", "ram_cs_n", 32'(ram_cs_n), 32'h3);
        chk("R11", "io/oe/we", 32'({io_cs_n, mem_oe_n, mem_we_n}), 32'h7);
        chk("R11", "doe/ready", 32'({mem_doe, req_ready}), 32'h0);
    endtask

    task automatic t_sram_word();
        access(1'b1, 2'd2, 32'h4000_0004, 32'h1122_3344);
        chk("R3", "ram write latency", 32'(r_lat), 32'd3);
        chk("R3", "ram write strobe cycles", 32'(r_we), 32'd2);
        chk("R3", "single ready", 32'(r_rdy), 32'd1);
        chk("R3", "setup cycle", 32'(r_setup_ok), 32'd1);
        chk("R2", "bank 0 select", 32'(r_cs), 32'b00010);
        chk("R4", "gap cycle idle", 32'(r_tail_ok), 32'd1);
        chk("R7", "word lanes", 32'(r_bsel), 32'h0);
        chk("R9", "doe held in gap", 32'(r_tail_doe), 32'd1);
        chk("R9", "doe window", 32'(r_doe_bad), 32'd0);
        chk("R9", "dout held in gap", r_dout_tail, r_dout_we);
        chk("R7", "dout value", r_dout_we, 32'h1122_3344);
        access(1'b1, 2'd2, 32'h4000_0404, 32'hCAFE_F00D);
        chk("R2", "bank 1 select", 32'(r_cs), 32'b00100);
        access(1'b0, 2'd2, 32'h4000_0004, 32'h0);
        chk("R5", "bank 0 readback", r_rdata, 32'h1122_3344);
        chk("R3", "ram read strobe cycles", 32'(r_oe), 32'd2);
        chk("R9", "no doe on read", 32'({r_tail_doe, 1'b0}) | 32'(r_doe_bad), 32'd0);
        access(1'b0, 2'd2, 32'h4000_0404, 32'h0);
        chk("R2", "bank 1 readback", r_rdata, 32'hCAFE_F00D);
    endtask

    task automatic t_prom_read();
        access(1'b0, 2'd2, 32'h0000_0010, 32'h0);
        chk("R6", "rom bank 0 word", r_rdata, 32'hB5B4_B7B6);
        chk("R6", "rom read latency", 32'(r_lat), 32'd13);
        chk("R6", "rom strobe cycles", 32'(r_oe), 32'd12);
        chk("R1", "rom bank 0 select", 32'(r_cs), 32'b01000);
        access(1'b0, 2'd2, 32'h0010_0020, 32'h0);
        chk("R6", "rom bank 1 word", r_rdata, 32'h1C1D_1E1F);
        chk("R1", "rom bank 1 select", 32'(r_cs), 32'b10000);
    endtask

    task automatic t_io_lanes();
        access(1'b1, 2'd2, 32'h2000_0008, 32'hA0B0_C0D0);
        chk("R3", "io write latency", 32'(r_lat), 32'd5);
        chk("R1", "io select", 32'(r_cs), 32'b00001);
        access(1'b1, 2'd0, 32'h2000_0009, 32'h00EE_0000);
        chk("R7", "byte offset 1 lanes", 32'(r_bsel), 32'b1011);
        access(1'b1, 2'd1, 32'h2000_000A, 32'h0000_1234);
        chk("R7", "half offset 2 lanes", 32'(r_bsel), 32'b1100);
        access(1'b0, 2'd2, 32'h2000_0008, 32'h0);
        chk("R7", "io merged readback", r_rdata, 32'hA0EE_1234);
        chk("R5", "io read latency", 32'(r_lat), 32'd5);
    endtask

    task automatic t_rmw();
        access(1'b1, 2'd2, 32'h4000_0008, 32'h5566_7788);
        access(1'b1, 2'd0, 32'h4000_000B, 32'h0000_00AB);
        chk("R8", "rmw latency", 32'(r_lat), 32'd6);
        chk("R8", "rmw read cycles", 32'(r_oe), 32'd2);
        chk("R8", "rmw write cycles", 32'(r_we), 32'd2);
        chk("R8", "rmw single ready", 32'(r_rdy), 32'd1);
        chk("R8", "rmw full lanes", 32'(r_bsel), 32'h0);
        chk("R8", "rmw merged word", r_dout_we, 32'h5566_77AB);
        access(1'b1, 2'd1, 32'h4000_0008, 32'h9999_0000);
        access(1'b0, 2'd2, 32'h4000_0008, 32'h0);
        chk("R8", "rmw readback", r_rdata, 32'h9999_77AB);
    endtask

    task automatic t_prom_write();
        access(1'b1, 2'd2, 32'h0000_0010, 32'hFFFF_FFFF);
        chk("R10", "rom write latency", 32'(r_lat), 32'd1);
        chk("R10", "rom write strobes", 32'(r_oe + r_we), 32'd0);
        chk("R10", "rom write selects", 32'(r_cs), 32'd0);
        chk("R10", "rom write no doe", 32'(r_tail_doe), 32'd0);
    endtask

    task automatic t_back_to_back();
        int c = 0;
        req_write = 1'b1; req_size = 2'd2; req_addr = 32'h4000_000C;
        req_wdata = 32'h0102_0304; req_valid = 1'b1;
        do begin @(negedge clk); c++; end while (!req_ready && c < 100);
        req_write = 1'b0;
        @(negedge clk);
        chk("R4", "gap between accesses", 32'(cs_vec()), 32'd0);
        @(negedge clk);
        chk("R4", "next setup follows gap", 32'({cs_vec(), mem_oe_n}), 32'b000101);
        c = 0;
        while (!req_ready && c < 100) begin @(negedge clk); c++; end
        chk("R5", "back-to-back read", req_rdata, 32'h0102_0304);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_sram_word();
        t_prom_read();
        t_io_lanes();
        t_rmw();
        t_prom_write();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule